// File: doc/BRIEF.md
# Time-of-Day Calendar Counter

This block keeps wall-clock time and calendar date (seconds, minutes, hours, day of month, month, year and century) in byte-wide registers. A host reaches them through two addresses. Address 0 holds an index, and address 1 reads or writes the register that the index points at. A prescaler divides a 32.768 kHz strobe down to one update per second. At each update, every carry from seconds up to year is applied in a single clock cycle. A host read therefore never sees a half-finished update.

Two control registers choose how the block behaves. They select BCD or plain binary data format, 12-hour or 24-hour hour format, and a set-inhibit that freezes the time while software loads it. They also hold a divider control that stops the prescaler and restarts it so that the first update arrives half a second after release. An update-in-progress flag in the first control register warns software of each coming update a few strobe periods before it happens.

Top module: `tod_calendar`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0x00, day and month read 0x01, and century reads 0x20. Control A reads 0x70, so the divider is held. Control B reads 0x02, which selects BCD and 24-hour format.
- R2: A write with `host_a0`=0 loads the index from `host_wdata[3:0]`. A write with `host_a0`=1 loads the indexed register. `host_rdata` always shows the indexed register. The index map is: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 century, 7 control A, 8 control B. Any other index reads 0x00.
- R3: The divider runs only while control A bits 6:4 equal 3'b010. Any other code holds the prescaler at its half-second point, and no update happens.
- R4: When the divider code changes to 3'b010, the first update comes after TICKS_PER_SEC/2 strobes. Each later update comes TICKS_PER_SEC strobes after the one before it.
- R5: Control A bit 7 is the update-in-progress flag. It reads 1 for the UIP_TICKS strobe periods just before each update and 0 once the update is done. Host writes change only bits 6:0 of control A.
- R6: While control B bit 7 (set-inhibit) is 1, the time registers change only by host writes and the update flag reads 0. After that bit is cleared, the next update increments seconds.
- R7: With control B bit 2 = 0, all time and date fields count in packed BCD, with decimal carries. For example, 09:59:59 becomes 10:00:00.
- R8: With control B bit 2 = 1, all fields count in plain binary.
- R9: With control B bit 1 = 1 (24-hour format), 23:59:59 becomes 00:00:00 and the day advances.
- R10: With control B bit 1 = 0 (12-hour format), hour bit 7 is the PM flag and the low bits hold 1 to 12. The hour steps 11 AM to 12 PM to 1 PM, and 11 PM to 12 AM to 1 AM. In BCD, 12 PM is 0x92 and 12 AM is 0x12. In binary, 12 PM is 0x8C and 12 AM is 0x0C.
- R11: The day of month rolls to 1 after the last day of the month. February has 29 days when the year value is a multiple of 4 and 28 days otherwise. April, June, September and November have 30 days.
- R12: Month 12 rolls to month 1 and increments the year. Year 99 rolls to 0. The century register is never changed by an update.
- R13: A time register changes only in an update cycle or a host write cycle. All carries of one update appear in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe at 32.768 kHz |
| host_we | input | 1 | Host write strobe |
| host_a0 | input | 1 | 0 selects the index, 1 selects the data register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Content of the indexed register |

## Verification
The bench targets the rollover edges:
- 12-hour noon and midnight transitions in both formats. A design that applied the PM flag to the wrong hour, or counted 12 as 0, would read 0x80 or 0x00.
- Month ends in leap and common years, and the end of a century. A wrong month-length table lands on day 29, 30 or 32, and a year that carries into the century changes the century register.

It measures the strobe count from divider release to the rise and fall of the update flag. An off-by-one in the half-second preset or the window length therefore shows up as an exact count mismatch. The set-inhibit test catches a clock that keeps counting or shows the update flag while frozen. Randomized times near the boundaries cover mixed carry chains in all four format combinations.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int unsigned NUM_FIELDS = 7;

  // Field order equals the host index of each field.
  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HOUR = 2;
  localparam int unsigned F_DAY  = 3;
  localparam int unsigned F_MON  = 4;
  localparam int unsigned F_YEAR = 5;
  localparam int unsigned F_CENT = 6;

  localparam logic [3:0] IX_CTLA = 4'd7;
  localparam logic [3:0] IX_CTLB = 4'd8;

  // Control B bit positions
  localparam int unsigned B_SET = 7;
  localparam int unsigned B_BIN = 2;
  localparam int unsigned B_H24 = 1;

  localparam logic [2:0] DIV_RUN = 3'b010;

  typedef logic [NUM_FIELDS-1:0][7:0] tod_t;

  localparam tod_t       TOD_RESET  = {8'h20, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam logic [6:0] CTLA_RESET = 7'h70;
  localparam logic [7:0] CTLB_RESET = 8'h02;

  // Register encoding -> binary value
  function automatic logic [6:0] fld_to_bin(input logic [7:0] v, input logic is_bin);
    logic [7:0] t;
    t = ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    return is_bin ? v[6:0] : t[6:0];
  endfunction

  // Binary value -> register encoding
  function automatic logic [7:0] bin_to_fld(input logic [6:0] v, input logic is_bin);
    logic [6:0] q;
    logic [6:0] r;
    q = v / 7'd10;
    r = v - q * 7'd10;
    return is_bin ? {1'b0, v} : {q[3:0], r[3:0]};
  endfunction

  function automatic logic [6:0] days_in_month(input logic [6:0] mon, input logic [1:0] yr_lo);
    logic [6:0] n;
    case (mon)
      7'd2:                    n = (yr_lo == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: n = 7'd30;
      default:                 n = 7'd31;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned UIP_TICKS     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_i,
  output logic upd_o,
  output logic uip_o
);

  localparam int unsigned   CNT_W     = $clog2(TICKS_PER_SEC);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(TICKS_PER_SEC - 1);
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(TICKS_PER_SEC / 2);
  localparam logic [CNT_W-1:0] UIP_C   = CNT_W'(TICKS_PER_SEC - UIP_TICKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = !run_i || tick_i;
    if (!run_i) begin
      cnt_d = HALF_C;
    end else if (cnt_q == LAST_C) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= HALF_C;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign upd_o = run_i && tick_i && (cnt_q == LAST_C);
  assign uip_o = run_i && (cnt_q >= UIP_C);

  assert_uip_precedes_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> uip_o);

  assert_uip_clears_after_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !uip_o);

  assert_divider_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == HALF_C) && !upd_o);

endmodule

// File: rtl/tod_advance.sv
module tod_advance
  import tod_pkg::*;
(
  input  tod_t cur_i,
  input  logic bin_i,
  input  logic h24_i,
  output tod_t nxt_o
);

  logic [6:0] s, m, h12, h, d, mo, y, dim, h_n, h12_n;
  logic       pm_in, pm_n;
  logic       c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    s   = fld_to_bin(cur_i[F_SEC],  bin_i);
    m   = fld_to_bin(cur_i[F_MIN],  bin_i);
    d   = fld_to_bin(cur_i[F_DAY],  bin_i);
    mo  = fld_to_bin(cur_i[F_MON],  bin_i);
    y   = fld_to_bin(cur_i[F_YEAR], bin_i);

    // hour normalised to 0..23
    pm_in = cur_i[F_HOUR][7] & ~h24_i;
    h12   = fld_to_bin({1'b0, cur_i[F_HOUR][6:0]}, bin_i);
    if (h24_i) begin
      h = fld_to_bin(cur_i[F_HOUR], bin_i);
    end else begin
      h = (h12 == 7'd12) ? 7'd0 : h12;
      if (pm_in) h = h + 7'd12;
    end

    dim   = days_in_month(mo, y[1:0]);
    c_min = (s >= 7'd59);
    c_hr  = c_min && (m >= 7'd59);
    c_day = c_hr && (h >= 7'd23);
    c_mon = c_day && (d >= dim);
    c_yr  = c_mon && (mo >= 7'd12);

    h_n   = (h >= 7'd23) ? 7'd0 : h + 7'd1;
    pm_n  = (h_n >= 7'd12);
    h12_n = pm_n ? h_n - 7'd12 : h_n;
    if (h12_n == 7'd0) h12_n = 7'd12;

    // untouched fields keep their exact encoding
    nxt_o = cur_i;
    nxt_o[F_SEC] = bin_to_fld(c_min ? 7'd0 : s + 7'd1, bin_i);
    if (c_min) nxt_o[F_MIN] = bin_to_fld(c_hr ? 7'd0 : m + 7'd1, bin_i);
    if (c_hr) begin
      if (h24_i) nxt_o[F_HOUR] = bin_to_fld(h_n, bin_i);
      else       nxt_o[F_HOUR] = {pm_n, 7'(bin_to_fld(h12_n, bin_i))};
    end
    if (c_day) nxt_o[F_DAY]  = bin_to_fld(c_mon ? 7'd1 : d + 7'd1, bin_i);
    if (c_mon) nxt_o[F_MON]  = bin_to_fld(c_yr ? 7'd1 : mo + 7'd1, bin_i);
    if (c_yr)  nxt_o[F_YEAR] = bin_to_fld((y >= 7'd99) ? 7'd0 : y + 7'd1, bin_i);
  end

endmodule

// File: rtl/tod_host_regs.sv
module tod_host_regs
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we_i,
  input  logic       host_a0_i,
  input  logic [7:0] host_wdata_i,
  input  logic       upd_i,
  input  logic       uip_i,
  input  tod_t       nxt_i,
  output tod_t       cur_o,
  output logic       div_run_o,
  output logic       bin_o,
  output logic       h24_o,
  output logic       set_o,
  output logic [7:0] host_rdata_o
);

  logic [3:0] idx_q, idx_d;
  logic [6:0] ctla_q, ctla_d;
  logic [7:0] ctlb_q, ctlb_d;
  logic [7:0] fld_q [NUM_FIELDS];
  logic       idx_en, ctla_en, ctlb_en;
  logic       data_wr, upd_fire, uip_vis;

  assign data_wr  = host_we_i && host_a0_i;
  assign upd_fire = upd_i && !ctlb_q[B_SET];
  assign uip_vis  = uip_i && !ctlb_q[B_SET];

  always_comb begin
    idx_en  = host_we_i && !host_a0_i;
    ctla_en = data_wr && (idx_q == IX_CTLA);
    ctlb_en = data_wr && (idx_q == IX_CTLB);
    idx_d   = host_wdata_i[3:0];
    ctla_d  = host_wdata_i[6:0];
    ctlb_d  = host_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= 4'd0;
      ctla_q <= CTLA_RESET;
      ctlb_q <= CTLB_RESET;
    end else begin
      if (idx_en)  idx_q  <= idx_d;
      if (ctla_en) ctla_q <= ctla_d;
      if (ctlb_en) ctlb_q <= ctlb_d;
    end
  end

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_fld
    logic       hit, en;
    logic [7:0] nxt;
    assign hit = data_wr && (idx_q == 4'(gi));
    assign en  = hit || upd_fire;
    assign nxt = hit ? host_wdata_i : nxt_i[gi];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  fld_q[gi] <= TOD_RESET[gi];
      else if (en) fld_q[gi] <= nxt;
    end

    assign cur_o[gi] = fld_q[gi];

    assert_field_only_on_event_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_i && !data_wr) |=> $stable(fld_q[gi]));
  end

  always_comb begin
    host_rdata_o = 8'h00;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (idx_q == 4'(i)) host_rdata_o = fld_q[i];
    end
    if (idx_q == IX_CTLA) host_rdata_o = {uip_vis, ctla_q};
    if (idx_q == IX_CTLB) host_rdata_o = ctlb_q;
  end

  assign div_run_o = (ctla_q[6:4] == DIV_RUN);
  assign bin_o     = ctlb_q[B_BIN];
  assign h24_o     = ctlb_q[B_H24];
  assign set_o     = ctlb_q[B_SET];

endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       host_we,
  input  logic       host_a0,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       div_run, upd, uip_win, fmt_bin, fmt_h24, set_hold, data_wr;
  tod_t       cur_time, nxt_time;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];
  assign data_wr = host_we && host_a0;

  tod_prescaler #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .UIP_TICKS    (UIP_TICKS)
  ) u_prescaler (
    .clk   (clk),
    .rst_n (rst_n_s),
    .tick_i(tick_32k),
    .run_i (div_run),
    .upd_o (upd),
    .uip_o (uip_win)
  );

  tod_advance u_advance (
    .cur_i(cur_time),
    .bin_i(fmt_bin),
    .h24_i(fmt_h24),
    .nxt_o(nxt_time)
  );

  tod_host_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .host_we_i   (host_we),
    .host_a0_i   (host_a0),
    .host_wdata_i(host_wdata),
    .upd_i       (upd),
    .uip_i       (uip_win),
    .nxt_i       (nxt_time),
    .cur_o       (cur_time),
    .div_run_o   (div_run),
    .bin_o       (fmt_bin),
    .h24_o       (fmt_h24),
    .set_o       (set_hold),
    .host_rdata_o(host_rdata)
  );

  assert_set_freezes_time_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (set_hold && !data_wr) |=> $stable(cur_time));

  assert_binary_second_step_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (upd && !set_hold && !data_wr && fmt_bin && cur_time[F_SEC] < 8'd59)
    |=> cur_time[F_SEC] == $past(cur_time[F_SEC]) + 8'd1);

  assert_bcd_digit_range_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (upd && !set_hold && !data_wr && !fmt_bin &&
     cur_time[F_SEC][3:0] <= 4'd9 && cur_time[F_SEC][7:4] <= 4'd5)
    |=> cur_time[F_SEC][3:0] <= 4'd9);

  assert_hour24_range_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (upd && !set_hold && !data_wr && fmt_bin && fmt_h24 && cur_time[F_HOUR] < 8'd24)
    |=> cur_time[F_HOUR] < 8'd24);

  assert_hour12_range_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (upd && !set_hold && !data_wr && fmt_bin && !fmt_h24 &&
     cur_time[F_HOUR][6:0] >= 7'd1 && cur_time[F_HOUR][6:0] <= 7'd12)
    |=> cur_time[F_HOUR][6:0] >= 7'd1 && cur_time[F_HOUR][6:0] <= 7'd12);

  assert_century_untouched_R12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (upd && !data_wr) |=> $stable(cur_time[F_CENT]));

endmodule

// File: tb/tod_calendar_bench.sv
module tod_calendar_bench;

  localparam int TPS  = 64;
  localparam int UIPT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic       a0 = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int n_checks = 0;
  int n_err    = 0;
  int ticks_total = 0;

  int m_h, m_mi, m_s, m_d, m_mo, m_y;

  tod_calendar #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) u_tod_calendar (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick),
    .host_we(we), .host_a0(a0), .host_wdata(wdata), .host_rdata(rdata)
  );

  always #4 clk = ~clk;

  always @(negedge clk) tick <= rst_n ? ~tick : 1'b0;
  always @(posedge clk) if (tick) ticks_total <= ticks_total + 1;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(string req, string what, int got, int exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] idx, logic [7:0] val);
    @(negedge clk); we = 1'b1; a0 = 1'b0; wdata = {4'h0, idx};
    @(negedge clk); a0 = 1'b1; wdata = val;
    @(negedge clk); we = 1'b0; a0 = 1'b0;
  endtask

  task automatic rd(logic [3:0] idx, output logic [7:0] val);
    @(negedge clk); we = 1'b1; a0 = 1'b0; wdata = {4'h0, idx};
    @(negedge clk); we = 1'b0;
    val = rdata;
  endtask

  task automatic set_index(logic [3:0] idx);
    @(negedge clk); we = 1'b1; a0 = 1'b0; wdata = {4'h0, idx};
    @(negedge clk); we = 1'b0;
  endtask

  function automatic logic [7:0] enc(int v, bit bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] hour_enc(int h, bit bin, bit h24);
    int h12;
    if (h24) return enc(h, bin);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return {(h >= 12), 7'(enc(h12, bin))};
  endfunction

  function automatic int dim_of(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_mi++;
    if (m_mi < 60) return;
    m_mi = 0; m_h++;
    if (m_h < 24) return;
    m_h = 0; m_d++;
    if (m_d <= dim_of(m_mo, m_y)) return;
    m_d = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_y = (m_y + 1) % 100;
  endtask

  task automatic wait_update(string req);
    int k;
    set_index(4'd7);
    k = 0;
    while (!rdata[7] && k < 2000) begin @(negedge clk); k++; end
    while (rdata[7] && k < 2000) begin @(negedge clk); k++; end
    if (k >= 2000) chk(req, "update wait", 0, 1);
  endtask

  task automatic run_case(string req, bit bin, bit h24, int h, int mi, int s, int d, int mo, int y);
    logic [7:0] v;
    wr(4'd7, 8'h70);
    wr(4'd8, {5'b0, bin, h24, 1'b0});
    wr(4'd0, enc(s, bin));
    wr(4'd1, enc(mi, bin));
    wr(4'd2, hour_enc(h, bin, h24));
    wr(4'd3, enc(d, bin));
    wr(4'd4, enc(mo, bin));
    wr(4'd5, enc(y, bin));
    wr(4'd6, enc(20, bin));
    wr(4'd7, 8'h26);
    m_h = h; m_mi = mi; m_s = s; m_d = d; m_mo = mo; m_y = y;
    model_step();
    wait_update(req);
    rd(4'd0, v); chk(req, "sec",  v, enc(m_s, bin));
    rd(4'd1, v); chk(req, "min",  v, enc(m_mi, bin));
    rd(4'd2, v); chk(req, "hour", v, hour_enc(m_h, bin, h24));
    rd(4'd3, v); chk(req, "day",  v, enc(m_d, bin));
    rd(4'd4, v); chk(req, "mon",  v, enc(m_mo, bin));
    rd(4'd5, v); chk(req, "year", v, enc(m_y, bin));
    rd(4'd6, v); chk(req, "cent", v, enc(20, bin));
  endtask

  initial begin
    logic [7:0] v;
    int base;
    int seed;
    bit seen;
    seed = $urandom(32'd20240229);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(4'd0, v); chk("R1", "sec",   v, 8'h00);
    rd(4'd2, v); chk("R1", "hour",  v, 8'h00);
    rd(4'd3, v); chk("R1", "day",   v, 8'h01);
    rd(4'd4, v); chk("R1", "mon",   v, 8'h01);
    rd(4'd6, v); chk("R1", "cent",  v, 8'h20);
    rd(4'd7, v); chk("R1", "ctl a", v, 8'h70);
    rd(4'd8, v); chk("R1", "ctl b", v, 8'h02);

    // R2 index/data access
    wr(4'd3, 8'h15);
    rd(4'd3, v); chk("R2", "day write", v, 8'h15);
    rd(4'hC, v); chk("R2", "unused index", v, 8'h00);

    // R5 bit 7 of control A is not writable
    wr(4'd7, 8'hF0);
    rd(4'd7, v); chk("R5", "ctl a bit7 ignored", v, 8'h70);

    // R3 divider held in reset and with a non-run code
    wr(4'd0, 8'h10);
    repeat (400) @(negedge clk);
    rd(4'd0, v); chk("R3", "held by 111", v, 8'h10);
    wr(4'd7, 8'h30);
    repeat (400) @(negedge clk);
    rd(4'd0, v); chk("R3", "held by 011", v, 8'h10);
    rd(4'd7, v); chk("R3", "ctl a readback", v, 8'h30);

    // R4 / R5 update timing after release
    wr(4'd7, 8'h70);
    wr(4'd7, 8'h26);
    base = ticks_total;
    set_index(4'd7);
    while (!rdata[7]) @(negedge clk);
    chk("R5", "first uip rise ticks", ticks_total - base, TPS/2 - UIPT);
    while (rdata[7]) @(negedge clk);
    chk("R4", "first update ticks", ticks_total - base, TPS/2);
    while (!rdata[7]) @(negedge clk);
    chk("R5", "second uip rise ticks", ticks_total - base, TPS/2 + TPS - UIPT);
    while (rdata[7]) @(negedge clk);
    chk("R4", "second update ticks", ticks_total - base, TPS/2 + TPS);

    // R13 all carries land in the update cycle
    wr(4'd7, 8'h70);
    wr(4'd8, 8'h02);
    wr(4'd2, 8'h10); wr(4'd1, 8'h59); wr(4'd0, 8'h59);
    wr(4'd7, 8'h26);
    base = ticks_total;
    set_index(4'd1);
    while (rdata == 8'h59 && ticks_total - base < 200) @(negedge clk);
    chk("R13", "minute carry ticks", ticks_total - base, TPS/2);
    chk("R13", "minute value", rdata, 8'h00);
    rd(4'd2, v); chk("R13", "hour value", v, 8'h11);
    rd(4'd0, v); chk("R13", "sec value", v, 8'h00);

    // R6 set-inhibit
    wr(4'd7, 8'h70);
    wr(4'd8, 8'h82);
    wr(4'd0, 8'h58); wr(4'd1, 8'h04); wr(4'd2, 8'h02);
    wr(4'd7, 8'h26);
    set_index(4'd7);
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (rdata[7]) seen = 1'b1; end
    chk("R6", "uip while set", seen, 0);
    rd(4'd0, v); chk("R6", "sec frozen", v, 8'h58);
    rd(4'd1, v); chk("R6", "min frozen", v, 8'h04);
    wr(4'd8, 8'h02);
    wait_update("R6");
    rd(4'd0, v); chk("R6", "sec after release", v, 8'h59);

    // directed format and calendar corners
    run_case("R7",  0, 1,  9, 59, 59,  2,  2, 11);
    run_case("R8",  1, 1,  9, 59, 59,  2,  2, 11);
    run_case("R8",  1, 1, 23, 59, 59, 15,  6, 40);
    run_case("R9",  0, 1, 23, 59, 59,  2,  2, 11);
    run_case("R10", 0, 0, 13, 59,  0,  2,  2, 11);
    run_case("R10", 0, 0, 11, 59, 59,  2,  2, 11);
    run_case("R10", 0, 0, 12, 59, 59,  2,  2, 11);
    run_case("R10", 0, 0, 23, 59, 59,  2,  2, 11);
    run_case("R10", 0, 0,  0, 59, 59,  2,  2, 11);
    run_case("R10", 1, 0, 11, 59, 59,  2,  2, 11);
    run_case("R10", 1, 0, 12, 59, 59,  2,  2, 11);
    run_case("R10", 1, 0, 23, 59, 59,  2,  2, 11);
    run_case("R10", 1, 0,  0, 59, 59,  2,  2, 11);
    run_case("R11", 0, 1, 23, 59, 59, 28,  2, 24);
    run_case("R11", 0, 1, 23, 59, 59, 29,  2, 24);
    run_case("R11", 0, 1, 23, 59, 59, 28,  2, 23);
    run_case("R11", 1, 1, 23, 59, 59, 30,  4, 11);
    run_case("R11", 1, 0, 23, 59, 59, 31,  1, 11);
    run_case("R12", 0, 1, 23, 59, 59, 31, 12, 99);
    run_case("R12", 1, 1, 23, 59, 59, 31, 12, 50);

    // random mix near the boundaries
    for (int i = 0; i < 24; i++) begin
      bit rb, rh;
      int rs, rm, rhr, rmo, ry, rd_;
      rb  = 1'($urandom % 2);
      rh  = 1'($urandom % 2);
      rs  = ($urandom % 2) ? 59 : int'($urandom % 60);
      rm  = ($urandom % 2) ? 59 : int'($urandom % 60);
      rhr = ($urandom % 3 == 0) ? 23 : int'($urandom % 24);
      rmo = 1 + int'($urandom % 12);
      ry  = int'($urandom % 100);
      rd_ = ($urandom % 2) ? dim_of(rmo, ry) : 1 + int'($urandom % dim_of(rmo, ry));
      run_case("R11 random", rb, rh, rhr, rm, rs, rd_, rmo, ry);
    end

    summary();
    $finish;
  end

endmodule